// File: doc/BRIEF.md
# Debug Bus Register Target

This block is a system-clock slave on a simple debug access bus. It holds a small bank of 32-bit registers selected by an 8-bit address and serves one read or one write per request. A master raises a request line with the address, the write data and a direction flag all valid in that same cycle. The slave acknowledges, returns read data, and keeps acknowledge and data steady until the master drops the request.

The handshake is a two-state machine. In `HS_IDLE` the slave waits for a request. The transition `accept` is taken when the request is sampled high in `HS_IDLE`. On that edge the access is carried out: the addressed register is written, or its value is captured into the read-data register. The machine then enters `HS_ACK`, where acknowledge is high. The transition `release` is taken when the request is sampled low in `HS_ACK`, and it returns the machine to `HS_IDLE`. A request held high never re-enters `accept`, so every request performs exactly one access.

Addresses at or above the bank size are unimplemented. They read as zero, and writes to them change nothing. The handshake completes normally for them.

Top module: `dbg_reg_target`

## Requirements
- R1: A synchronous active-high reset deasserts acknowledge, clears the read-data output to zero and clears every register to zero.
- R2: Acknowledge rises on the first clock edge at which the request is sampled high while acknowledge is low. It never rises without a request.
- R3: Acknowledge stays high while the request stays high. It falls on the first clock edge at which the request is sampled low.
- R4: A request with the direction flag at 1 stores the presented write data in the register at the presented address (addresses 0 to 7 with the default bank of 8).
- R5: A request with the direction flag at 0 places the addressed register's value on the read-data output by the edge that raises acknowledge. The output does not change while acknowledge is high.
- R6: A request held high for any number of cycles performs its access only once. Changes to address, data or direction after the accepting edge have no effect.
- R7: Reads from addresses 8 to 255 return zero. Writes to those addresses alter no register, and their handshake completes like any other.
- R8: The read-data output changes only when a read is accepted. A write leaves it at the previous read's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request from the master |
| addr_i | input | 8 | Register address, valid with the request |
| wr_i | input | 1 | Direction: 1 = write, 0 = read |
| wdata_i | input | 32 | Write data, valid with the request |
| ack_o | output | 1 | Acknowledge, held until the request falls |
| rdata_o | output | 32 | Read data, steady while acknowledge is high |

## Verification
The bench holds requests for many cycles and scrambles address, data and direction while they are held. A slave that re-triggered on a level request would write the scrambled values or let the read data drift. Writes to unimplemented addresses are followed by reads of every implemented register; a decoder that truncated the address would alias those writes onto low registers. Read data is checked after write-only stretches, to catch a slave that overwrites its read-data output on writes. A reset in the middle of traffic confirms that the bank and acknowledge return to their cleared values.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    // Handshake machine states
    typedef enum logic {
        HS_IDLE = 1'b0,
        HS_ACK  = 1'b1
    } hs_state_t;

endpackage

// File: rtl/dbg_hs_fsm.sv
module dbg_hs_fsm
    import dbg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic fire,
    output logic ack
);

    hs_state_t state_q;
    hs_state_t state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: accept (IDLE->ACK), release (ACK->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE: if (req)  state_d = HS_ACK;
            HS_ACK:  if (!req) state_d = HS_IDLE;
            default: state_d = HS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        fire = 1'b0;
        ack  = 1'b0;
        unique case (state_q)
            HS_IDLE: fire = req;
            HS_ACK:  ack  = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/dbg_regbank.sv
module dbg_regbank #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic              hit;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] regs [NUM_REGS];
    logic [DATA_W-1:0] sel_data;
    logic [DATA_W-1:0] rdata_q;

    // Full-width decode: only addresses below NUM_REGS are implemented
    assign hit = (addr < ADDR_W'(NUM_REGS));
    assign idx = addr[IDX_W-1:0];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we && hit && (idx == IDX_W'(g))) begin
                regs[g] <= wdata;
            end
        end
    end

    always_comb begin
        sel_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (hit && (idx == IDX_W'(i))) begin
                sel_data = regs[i];
            end
        end
    end

    // Read data is captured once per accepted read and then held
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (re) begin
            rdata_q <= sel_data;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/dbg_reg_target.sv
module dbg_reg_target #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic fire;

    dbg_hs_fsm u_fsm (
        .clk  (clk),
        .rst  (rst),
        .req  (req_i),
        .fire (fire),
        .ack  (ack_o)
    );

    dbg_regbank #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (fire && wr_i),
        .re    (fire && !wr_i),
        .addr  (addr_i),
        .wdata (wdata_i),
        .rdata (rdata_o)
    );

endmodule

// File: rtl/dbg_reg_target_chk.sv
module dbg_reg_target_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              wr,
    input logic              ack,
    input logic [DATA_W-1:0] rdata
);

    a_r2_ack_rise: assert property (@(posedge clk) disable iff (rst)
        (req && !ack) |=> ack);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (!req && !ack) |=> !ack);

    a_r3_ack_hold: assert property (@(posedge clk) disable iff (rst)
        (req && ack) |=> ack);

    a_r3_ack_fall: assert property (@(posedge clk) disable iff (rst)
        (ack && !req) |=> !ack);

    a_r5_data_stable: assert property (@(posedge clk) disable iff (rst)
        ack |=> $stable(rdata));

    a_r8_only_reads: assert property (@(posedge clk) disable iff (rst)
        !(req && !ack && !wr) |=> $stable(rdata));

endmodule

bind dbg_reg_target dbg_reg_target_chk #(.DATA_W(DATA_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .req   (req_i),
    .wr    (wr_i),
    .ack   (ack_o),
    .rdata (rdata_o)
);

// File: tb/dbg_reg_target_test.sv
module dbg_reg_target_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic        ack;
    logic [31:0] rdata;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    logic [31:0] model [8];
    logic [31:0] exp_dout;

    always #5 clk = ~clk;

    dbg_reg_target uut (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req),
        .addr_i  (addr),
        .wr_i    (wr),
        .wdata_i (wdata),
        .ack_o   (ack),
        .rdata_o (rdata)
    );

    function automatic logic [31:0] model_read(input logic [7:0] a);
        return (a < 8'd8) ? model[a[2:0]] : 32'h0;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) model[i] = '0;
        exp_dout = '0;
        check(ack == 1'b0, "R1 ack after reset", {31'b0, ack}, 32'h0);
        check(rdata == 32'h0, "R1 rdata after reset", rdata, 32'h0);
    endtask

    task automatic access(input logic [7:0] a, input logic w,
                          input logic [31:0] d, input int hold,
                          input bit scramble);
        logic [31:0] r;
        @(negedge clk);
        check(ack == 1'b0, "R2 ack low before request", {31'b0, ack}, 32'h0);
        req = 1'b1; addr = a; wr = w; wdata = d;
        if (!w) exp_dout = model_read(a);
        else if (a < 8'd8) model[a[2:0]] = d;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (i == 0) check(ack == 1'b1, "R2 ack rise", {31'b0, ack}, 32'h1);
            else        check(ack == 1'b1, "R3 ack held", {31'b0, ack}, 32'h1);
            check(rdata == exp_dout, "R5/R8 rdata during ack", rdata, exp_dout);
            if (scramble) begin
                r = $urandom;
                addr = r[7:0]; wr = r[8];
                wdata = $urandom;
            end
        end
        req = 1'b0;
        @(negedge clk);
        check(ack == 1'b0, "R3 ack fall", {31'b0, ack}, 32'h0);
        check(rdata == exp_dout, "R8 rdata after release", rdata, exp_dout);
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) model[i] = '0;
        exp_dout = '0;

        // R1: reset state, every address reads zero
        do_reset();
        for (int a = 0; a < 16; a++) access(8'(a), 1'b0, 32'h0, 1, 1'b0);

        // R4/R5: directed write then read back every register
        for (int a = 0; a < 8; a++) access(8'(a), 1'b1, 32'hA5000000 | 32'(a), 1, 1'b0);
        for (int a = 0; a < 8; a++) access(8'(a), 1'b0, 32'h0, 2, 1'b0);

        // R8: writes leave rdata at last read
        access(8'd2, 1'b0, 32'h0, 1, 1'b0);
        access(8'd5, 1'b1, 32'h12345678, 3, 1'b0);
        access(8'd6, 1'b1, 32'h87654321, 1, 1'b0);
        check(rdata == model[2], "R8 rdata unchanged by writes", rdata, model[2]);

        // R6: long held write with scrambled inputs performs once
        access(8'd3, 1'b1, 32'hCAFEF00D, 50, 1'b1);
        access(8'd3, 1'b0, 32'h0, 1, 1'b0);
        check(rdata == 32'hCAFEF00D, "R6 held write once", rdata, 32'hCAFEF00D);
        for (int a = 0; a < 8; a++) access(8'(a), 1'b0, 32'h0, 1, 1'b0);

        // R6: long held read with scrambled inputs keeps data
        access(8'd4, 1'b0, 32'h0, 40, 1'b1);

        // R7: writes above the bank must not alias onto registers
        access(8'd8,   1'b1, 32'hDEADBEEF, 1, 1'b0);
        access(8'd11,  1'b1, 32'hDEADBEEF, 2, 1'b0);
        access(8'd131, 1'b1, 32'hDEADBEEF, 1, 1'b0);
        access(8'd255, 1'b1, 32'hDEADBEEF, 1, 1'b0);
        for (int a = 0; a < 8; a++) access(8'(a), 1'b0, 32'h0, 1, 1'b0);
        access(8'd131, 1'b0, 32'h0, 1, 1'b0);
        check(rdata == 32'h0, "R7 unimplemented read zero", rdata, 32'h0);

        // Random traffic
        for (int n = 0; n < 400; n++) begin
            r = $urandom;
            access({3'b0, r[4:0]} | (r[5] ? 8'h0 : 8'h0), r[8],
                   $urandom, 1 + int'(r[11:9] & 3'd3), r[12]);
        end

        // R1: reset in the middle of traffic
        access(8'd1, 1'b1, 32'h0BADCAFE, 1, 1'b0);
        access(8'd1, 1'b0, 32'h0, 1, 1'b0);
        do_reset();
        for (int a = 0; a < 8; a++) access(8'(a), 1'b0, 32'h0, 1, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule